// File: doc/BRIEF.md
# Bulk Receive Pipe End-of-Transfer NAK Controller

This block owns the response state of one bulk OUT receive pipe. The state is either BUF, where the pipe accepts data, or NAK, where it refuses data. When automatic mode is switched on and the pipe is set for bulk transfers, the block watches each packet that the protocol engine reports as received. When one of those packets is the last of a transfer unit, the block moves the pipe to NAK by itself. The pipe then stays in NAK until software re-arms it. This lets a double-buffered receiver take data one transfer unit at a time.

A packet is the last of its unit in either of two cases. It may be short, meaning its length is below the configured maximum packet size; a zero-length packet counts as short. It may also take a software-loaded transaction counter from one down to zero. A software write of the response state always takes precedence. The block also drives a one-cycle pulse when an automatic NAK happens. The asynchronous reset input is released through a two-stage synchronizer inside the block.

Top module: `bulk_rx_nak_ctl`

## Requirements
- R1: While in reset, and after reset is released, `resp` is 0 (NAK), `trn_left` is 0 and `auto_nak` is 0.
- R2: A cycle with `sw_wr`=1 loads `sw_resp` into `resp` (1 = BUF, 0 = NAK) on the next clock edge, whatever the mode and transfer type.
- R3: With `auto_en`=1, `xfer_type`=2'd2 (bulk) and `resp`=1, a `pkt_done` whose `pkt_len` is less than `max_pkt` (zero length included) sets `resp` to 0 on the next edge. `auto_nak` is 1 for that cycle only.
- R4: `cnt_load` sets `trn_left` to `cnt_value` on the next edge. Each other `pkt_done` lowers a nonzero `trn_left` by one. At zero, `trn_left` stays at zero.
- R5: Under the conditions of R3, a `pkt_done` that takes `trn_left` from 1 to 0 is treated as final, even at full length.
- R6: After a load of zero, full-length packets never cause an automatic NAK.
- R7: For `xfer_type` values 0, 1 and 3 (control, isochronous, interrupt), `resp` changes only through software writes.
- R8: With `auto_en`=0, `resp` changes only through software writes.
- R9: Once `resp` is 0, further packets leave it at 0 and raise no `auto_nak`. Only a software write returns it to 1.
- R10: When `sw_wr` and a final packet arrive in the same cycle, the software value is taken and `auto_nak` stays 0.
- R11: When `cnt_load` and `pkt_done` arrive in the same cycle, the loaded value is taken without a decrement. That packet is not final by count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Enables automatic NAK on the final packet |
| xfer_type | input | 2 | Pipe transfer type: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| max_pkt | input | PKT_W | Maximum packet size in bytes |
| pkt_done | input | 1 | One-cycle strobe: a data packet was received and acknowledged |
| pkt_len | input | PKT_W | Length of the packet flagged by `pkt_done` |
| cnt_load | input | 1 | Loads the transaction counter |
| cnt_value | input | CNT_W | Value for `cnt_load`; zero turns off count-based detection |
| sw_wr | input | 1 | Software write of the response state |
| sw_resp | input | 1 | Value written by `sw_wr`: 1 BUF, 0 NAK |
| resp | output | 1 | Current response state: 1 BUF, 0 NAK |
| trn_left | output | CNT_W | Remaining transaction count |
| auto_nak | output | 1 | One-cycle pulse when an automatic NAK takes effect |

## Verification
Every output is a register, so each result shows up one clock edge after the input cycle that caused it. The bench drives inputs on the falling edge. On the next falling edge it compares `resp`, `trn_left` and `auto_nak` with a bench model that steps once for each driven cycle. Directed cases also check fixed expected values at those same falling edges. Strobes are cleared right after each compare, so one stimulus maps to exactly one compared cycle.

// File: rtl/rxnak_pkg.sv
package rxnak_pkg;
  typedef enum logic [1:0] {
    XT_CTRL = 2'd0,
    XT_ISOC = 2'd1,
    XT_BULK = 2'd2,
    XT_INTR = 2'd3
  } xfer_e;

  typedef enum logic {
    RSP_NAK = 1'b0,
    RSP_BUF = 1'b1
  } rsp_e;
endpackage

// File: rtl/rxnak_trn_counter.sv
module rxnak_trn_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             pkt_ok,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             nz;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    nz       = (cnt_q != '0);
    cnt_en   = load | (pkt_ok & nz);
    cnt_d    = load ? load_val : (cnt_q - ONE);
    // a load in the same cycle hides the packet from the count
    cnt_last = pkt_ok & ~load & (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rxnak_final_detect.sv
module rxnak_final_detect #(
  parameter int PKT_W = 11
) (
  input  logic             pkt_ok,
  input  logic [PKT_W-1:0] pkt_len,
  input  logic [PKT_W-1:0] max_pkt,
  input  logic             cnt_last,
  output logic             is_final
);
  logic short_pkt;

  always_comb begin
    short_pkt = (pkt_len < max_pkt);
    is_final  = pkt_ok & (short_pkt | cnt_last);
  end
endmodule

// File: rtl/rxnak_resp_reg.sv
module rxnak_resp_reg
  import rxnak_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic [1:0] xfer_type,
  input  logic       is_final,
  input  logic       sw_wr,
  input  logic       sw_resp,
  output logic       resp_q,
  output logic       pulse_q
);
  logic is_bulk;
  logic trig;
  logic resp_d;

  always_comb begin
    is_bulk = (xfer_type == XT_BULK);
    trig    = auto_en & is_bulk & is_final & (resp_q == RSP_BUF) & ~sw_wr;
    if (sw_wr) begin
      resp_d = sw_resp;
    end else if (trig) begin
      resp_d = RSP_NAK;
    end else begin
      resp_d = resp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q  <= RSP_NAK;
      pulse_q <= 1'b0;
    end else begin
      resp_q  <= resp_d;
      pulse_q <= trig;
    end
  end
endmodule

// File: rtl/bulk_rx_nak_ctl.sv
module bulk_rx_nak_ctl #(
  parameter int PKT_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic [1:0]       xfer_type,
  input  logic [PKT_W-1:0] max_pkt,
  input  logic             pkt_done,
  input  logic [PKT_W-1:0] pkt_len,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             sw_wr,
  input  logic             sw_resp,
  output logic             resp,
  output logic [CNT_W-1:0] trn_left,
  output logic             auto_nak
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync;
  logic              rst_q;
  logic              cnt_last;
  logic              is_final;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_q = rst_sync[SYNC_N-1];

  rxnak_trn_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_q),
    .load     (cnt_load),
    .load_val (cnt_value),
    .pkt_ok   (pkt_done),
    .cnt_q    (trn_left),
    .cnt_last (cnt_last)
  );

  rxnak_final_detect #(.PKT_W(PKT_W)) u_det (
    .pkt_ok   (pkt_done),
    .pkt_len  (pkt_len),
    .max_pkt  (max_pkt),
    .cnt_last (cnt_last),
    .is_final (is_final)
  );

  rxnak_resp_reg u_rsp (
    .clk       (clk),
    .rst_n     (rst_q),
    .auto_en   (auto_en),
    .xfer_type (xfer_type),
    .is_final  (is_final),
    .sw_wr     (sw_wr),
    .sw_resp   (sw_resp),
    .resp_q    (resp),
    .pulse_q   (auto_nak)
  );
endmodule

// File: rtl/rxnak_checker.sv
module rxnak_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_q,
  input logic             auto_en,
  input logic [1:0]       xfer_type,
  input logic             cnt_load,
  input logic [CNT_W-1:0] cnt_value,
  input logic             sw_wr,
  input logic             sw_resp,
  input logic             resp,
  input logic [CNT_W-1:0] trn_left,
  input logic             auto_nak
);
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_q) |-> (resp == 1'b0 && trn_left == '0 && auto_nak == 1'b0));

  a_r2_sw_write: assert property (@(posedge clk) disable iff (!rst_q)
    sw_wr |=> resp == $past(sw_resp));

  a_r3_pulse_lands_nak: assert property (@(posedge clk) disable iff (!rst_q)
    auto_nak |-> (resp == 1'b0 && $past(resp) == 1'b1));

  a_r4_cnt_floor: assert property (@(posedge clk) disable iff (!rst_q)
    (trn_left == '0 && !cnt_load) |=> trn_left == '0);

  a_r7_nonbulk_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (xfer_type != 2'd2 && !sw_wr) |=> (resp == $past(resp) && !auto_nak));

  a_r8_disabled_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (!auto_en && !sw_wr) |=> (resp == $past(resp) && !auto_nak));

  a_r9_nak_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    (resp == 1'b0 && !sw_wr) |=> (resp == 1'b0 && !auto_nak));

  a_r10_sw_no_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    sw_wr |=> !auto_nak);

  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_load |=> trn_left == $past(cnt_value));
endmodule

bind bulk_rx_nak_ctl rxnak_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .auto_en   (auto_en),
  .xfer_type (xfer_type),
  .cnt_load  (cnt_load),
  .cnt_value (cnt_value),
  .sw_wr     (sw_wr),
  .sw_resp   (sw_resp),
  .resp      (resp),
  .trn_left  (trn_left),
  .auto_nak  (auto_nak)
);

// File: tb/bulk_rx_nak_ctl_bench.sv
`timescale 1ns/1ps
module bulk_rx_nak_ctl_bench;
  localparam int PKT_W = 11;
  localparam int CNT_W = 8;

  logic             clk;
  logic             rst_n;
  logic             auto_en;
  logic [1:0]       xfer_type;
  logic [PKT_W-1:0] max_pkt;
  logic             pkt_done;
  logic [PKT_W-1:0] pkt_len;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_value;
  logic             sw_wr;
  logic             sw_resp;
  logic             resp;
  logic [CNT_W-1:0] trn_left;
  logic             auto_nak;

  int checks = 0;
  int errors = 0;
  logic             m_resp;
  logic [CNT_W-1:0] m_cnt;
  logic             m_pulse;

  bulk_rx_nak_ctl #(.PKT_W(PKT_W), .CNT_W(CNT_W)) u_bulk_rx_nak_ctl (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .xfer_type(xfer_type),
    .max_pkt(max_pkt), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .cnt_load(cnt_load), .cnt_value(cnt_value), .sw_wr(sw_wr),
    .sw_resp(sw_resp), .resp(resp), .trn_left(trn_left), .auto_nak(auto_nak)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic exp_final(input logic pd, input logic ld,
                                     input logic [PKT_W-1:0] len,
                                     input logic [PKT_W-1:0] mps,
                                     input logic [CNT_W-1:0] cnt);
    return pd && ((len < mps) || (!ld && cnt == CNT_W'(1)));
  endfunction

  function automatic logic [CNT_W-1:0] exp_cnt(input logic ld,
                                               input logic [CNT_W-1:0] val,
                                               input logic pd,
                                               input logic [CNT_W-1:0] cnt);
    if (ld) return val;
    if (pd && cnt != '0) return cnt - CNT_W'(1);
    return cnt;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic expect_out(input string tag, input logic r, input int c, input logic p);
    chk({tag, " resp"}, int'(resp), int'(r));
    chk({tag, " trn_left"}, int'(trn_left), c);
    chk({tag, " auto_nak"}, int'(auto_nak), int'(p));
  endtask

  // advance one cycle with the inputs now driven, then compare to the model
  task automatic tick(input string tag);
    logic trig;
    trig = auto_en && xfer_type == 2'd2 && m_resp && !sw_wr &&
           exp_final(pkt_done, cnt_load, pkt_len, max_pkt, m_cnt);
    m_cnt   = exp_cnt(cnt_load, cnt_value, pkt_done, m_cnt);
    m_resp  = sw_wr ? sw_resp : (trig ? 1'b0 : m_resp);
    m_pulse = trig;
    @(negedge clk);
    expect_out(tag, m_resp, int'(m_cnt), m_pulse);
    pkt_done = 1'b0;
    cnt_load = 1'b0;
    sw_wr    = 1'b0;
  endtask

  task automatic rearm();
    sw_wr = 1'b1; sw_resp = 1'b1; tick("R2");
  endtask

  task automatic pkt(input int len, input string tag);
    pkt_done = 1'b1; pkt_len = PKT_W'(len); tick(tag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; auto_en = 1'b0; xfer_type = 2'd2; max_pkt = PKT_W'(64);
    pkt_done = 1'b0; pkt_len = '0; cnt_load = 1'b0; cnt_value = '0;
    sw_wr = 1'b0; sw_resp = 1'b0;
    m_resp = 1'b0; m_cnt = '0; m_pulse = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R1 in reset", 1'b0, 0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_out("R1 after release", 1'b0, 0, 1'b0);

    // R2 software write
    rearm();
    expect_out("R2 write BUF", 1'b1, 0, 1'b0);
    sw_wr = 1'b1; sw_resp = 1'b0; tick("R2");
    expect_out("R2 write NAK", 1'b0, 0, 1'b0);
    rearm();

    // R3 short packet closes the pipe
    auto_en = 1'b1;
    pkt(64, "R3 full pkt");
    expect_out("R3 full keeps BUF", 1'b1, 0, 1'b0);
    pkt(10, "R3 short pkt");
    expect_out("R3 short to NAK", 1'b0, 0, 1'b1);
    tick("R3 pulse drop");
    expect_out("R3 pulse one cycle", 1'b0, 0, 1'b0);

    // R9 sticky NAK
    pkt(5, "R9");
    expect_out("R9 stays NAK", 1'b0, 0, 1'b0);
    rearm();
    pkt(0, "R3 zero length");
    expect_out("R3 ZLP to NAK", 1'b0, 0, 1'b1);
    rearm();

    // R4 / R5 counter
    cnt_load = 1'b1; cnt_value = CNT_W'(3); tick("R4 load");
    expect_out("R4 loaded", 1'b1, 3, 1'b0);
    pkt(64, "R4 dec");
    pkt(64, "R4 dec");
    expect_out("R4 count 1", 1'b1, 1, 1'b0);
    pkt(64, "R5 last by count");
    expect_out("R5 count NAK", 1'b0, 0, 1'b1);
    pkt(64, "R4 floor");
    expect_out("R4 stays zero", 1'b0, 0, 1'b0);
    rearm();

    // R6 zero load disables counting
    cnt_load = 1'b1; cnt_value = '0; tick("R6 load zero");
    for (int i = 0; i < 4; i++) pkt(64, "R6");
    expect_out("R6 still BUF", 1'b1, 0, 1'b0);

    // R7 other transfer types
    xfer_type = 2'd1; pkt(3, "R7 isoc");
    xfer_type = 2'd3; pkt(3, "R7 intr");
    xfer_type = 2'd0; pkt(0, "R7 ctrl");
    expect_out("R7 still BUF", 1'b1, 0, 1'b0);
    xfer_type = 2'd2;

    // R8 disabled
    auto_en = 1'b0; pkt(3, "R8");
    expect_out("R8 still BUF", 1'b1, 0, 1'b0);
    auto_en = 1'b1;

    // R10 software write wins
    sw_wr = 1'b1; sw_resp = 1'b1; pkt(3, "R10");
    expect_out("R10 BUF no pulse", 1'b1, 0, 1'b0);

    // R11 load wins over decrement
    cnt_load = 1'b1; cnt_value = CNT_W'(1); tick("R11 pre");
    cnt_load = 1'b1; cnt_value = CNT_W'(5); pkt(64, "R11");
    expect_out("R11 load taken", 1'b1, 5, 1'b0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      auto_en   = ($urandom % 8) != 0;
      xfer_type = (($urandom % 4) != 0) ? 2'd2 : 2'($urandom % 4);
      if ($urandom % 50 == 0) begin
        case ($urandom % 3)
          0: max_pkt = PKT_W'(8);
          1: max_pkt = PKT_W'(64);
          default: max_pkt = PKT_W'(512);
        endcase
      end
      pkt_done  = $urandom % 2;
      pkt_len   = (($urandom % 4) == 0) ? PKT_W'($urandom % int'(max_pkt)) : max_pkt;
      cnt_load  = ($urandom % 20) == 0;
      cnt_value = CNT_W'($urandom % 6);
      sw_wr     = ($urandom % 12) == 0;
      sw_resp   = ($urandom % 4) != 0;
      tick("R3 R4 R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule